// File: doc/BRIEF.md
# Modulo-6 Sequence Counter with Registered Display

This block counts enabled clock edges through the six values 0, 1, 2, 3, 4, 5 and then starts again at 0. It suits a divide-by-six tick generator or a six-phase sequencer. All of its flip-flops run from one shared clock. The next state is built as a toggle chain: a bit flips only when every bit below it is set. That AND carry is what lets the top bit step correctly from 3 to 4.

A build parameter selects how the count returns to 0. In last-value mode, the logic detects the value 5 and loads 0 at the next edge. In clear-on-overflow mode, the logic watches the incremented value. The moment that value reaches the overflow pattern, it is forced to 0 in the same cycle, so the count register never stores it. A second bank of D flip-flops copies the count one clock later. That copy drives the display output, so a downstream reader only ever sees settled, legal values.

A terminal-count strobe marks each enabled cycle in which the count sits on its last value. Control pins are plain levels. The block has no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `mod6_seq_counter`

## Requirements
- R1: While `rst` is high, `count_q` and `disp_q` are 0 at the next edge, and `tc_pulse` is 0 whenever `cnt_en` is low.
- R2: When `cnt_en` is high and `count_q` is below 5, `count_q` increases by exactly one at the next edge.
- R3: When `cnt_en` is high and `count_q` equals 5, `count_q` becomes 0 at the next edge.
- R4: `count_q` and `disp_q` never show 6 or 7.
- R5: When `cnt_en` is low, `count_q` keeps its value across the edge.
- R6: `tc_pulse` is high exactly in cycles where `count_q` equals 5 and `cnt_en` is high. The cycle after a pulse always shows `count_q` equal to 0.
- R7: `disp_q` equals the value `count_q` held one clock earlier.
- R8: With `WRAP_MODE` set to clear-on-overflow (encoding 1), the port-visible sequence is the same as in last-value mode (encoding 0): 0 through 5, then 0.
- R9: The step from 2 goes to 3 and the step from 3 goes to 4. The top bit toggles only when the two lower bits are both set, so the sequence never jumps 0, 1, 2, 7.

Parameters:
- `MODULUS` (default 6) is the number of states. The count width is derived as ceil(log2(`MODULUS`)).
- `WRAP_MODE` selects the wrap strategy: 0 is last-value wrap, 1 is clear-on-overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for every flip-flop |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable; low holds the count |
| count_q | output | 3 | Registered count, 0 to 5 |
| disp_q | output | 3 | Display copy of `count_q`, one clock late |
| tc_pulse | output | 1 | High while the count is 5 and enable is high |

## Verification
Three things can coincide in one cycle: the wrap from 5 to 0, the terminal-count strobe, and the display still showing the previous value. The bench provokes this by running long enabled stretches. It also parks the count on 5 with the enable low, then raises the enable. The scoreboard judges the count, the strobe and the lagging display together in each of those cycles. It does so for both wrap modes at once, with both instances driven by the same enable. A reset applied while the count is mid-sequence shows that the count and the display both return to 0 and then restart in step.

// File: rtl/mod6_pkg.sv
package mod6_pkg;
  typedef enum logic {
    WRAP_AT_LAST  = 1'b0,
    CLEAR_AT_OVER = 1'b1
  } wrap_mode_e;
endpackage

// File: rtl/mcnt_incr.sv
// Toggle-chain incrementer: each bit flips when every lower bit is set.
module mcnt_incr #(
  parameter int W = 3
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] inc
);
  logic [W:0] carry;

  assign carry[0] = 1'b1;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign carry[i+1] = carry[i] & cur[i];
    assign inc[i]     = cur[i] ^ carry[i];
  end
endmodule

// File: rtl/mcnt_wrap.sv
// Next-state selection with the two wrap strategies.
module mcnt_wrap import mod6_pkg::*; #(
  parameter int         W         = 3,
  parameter int         MODULUS   = 6,
  parameter wrap_mode_e WRAP_MODE = WRAP_AT_LAST
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] inc,
  input  logic         en,
  output logic [W-1:0] nxt,
  output logic         at_last
);
  localparam logic [W-1:0] LAST_V = W'(MODULUS - 1);
  localparam logic [W-1:0] OVER_V = W'(MODULUS);

  assign at_last = (cur == LAST_V);

  if (WRAP_MODE == WRAP_AT_LAST) begin : g_last
    // Detect the last legal value and load zero on the next edge.
    always_comb begin
      if (!en)          nxt = cur;
      else if (at_last) nxt = '0;
      else              nxt = inc;
    end
  end else begin : g_over
    // AND only the bits that are set in the overflow pattern; a hit
    // clears the value before it can be stored.
    logic over_hit;
    assign over_hit = &(inc | ~OVER_V);
    always_comb begin
      if (!en)           nxt = cur;
      else if (over_hit) nxt = '0;
      else               nxt = inc;
    end
  end
endmodule

// File: rtl/mcnt_disp.sv
// One-clock display buffer.
module mcnt_disp #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] disp
);
  always_ff @(posedge clk) begin
    if (rst) disp <= '0;
    else     disp <= cnt;
  end

  // R7: the display follows the count one clock late
  a_r7_disp_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (disp == $past(cnt)));
endmodule

// File: rtl/mod6_seq_counter.sv
module mod6_seq_counter import mod6_pkg::*; #(
  parameter int         MODULUS   = 6,
  parameter wrap_mode_e WRAP_MODE = WRAP_AT_LAST,
  localparam int        CNT_W     = $clog2(MODULUS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] disp_q,
  output logic             tc_pulse
);
  localparam logic [CNT_W-1:0] LAST_V = CNT_W'(MODULUS - 1);

  logic [CNT_W-1:0] inc_v;
  logic [CNT_W-1:0] nxt_v;
  logic             at_last;

  mcnt_incr #(.W(CNT_W)) u_incr (
    .cur (count_q),
    .inc (inc_v)
  );

  mcnt_wrap #(.W(CNT_W), .MODULUS(MODULUS), .WRAP_MODE(WRAP_MODE)) u_wrap (
    .cur     (count_q),
    .inc     (inc_v),
    .en      (cnt_en),
    .nxt     (nxt_v),
    .at_last (at_last)
  );

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= nxt_v;
  end

  assign tc_pulse = at_last & cnt_en;

  mcnt_disp #(.W(CNT_W)) u_disp (
    .clk  (clk),
    .rst  (rst),
    .cnt  (count_q),
    .disp (disp_q)
  );

  // R4: no illegal value is ever stored
  a_r4_legal: assert property (@(posedge clk) disable iff (rst)
    (count_q < CNT_W'(MODULUS)) && (disp_q < CNT_W'(MODULUS)));
  // R2: one step up per enabled edge below the last value
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && count_q != LAST_V) |=> (count_q == $past(count_q) + 1'b1));
  // R3: wrap from the last value
  a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && count_q == LAST_V) |=> (count_q == '0));
  // R5: hold while disabled
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> $stable(count_q));
  // R6: a strobe is always followed by zero
  a_r6_tc_then_zero: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |=> (count_q == '0));
endmodule

// File: tb/mod6_seq_counter_tb_top.sv
`timescale 1ns/1ps
module mod6_seq_counter_tb_top;
  import mod6_pkg::*;

  typedef struct {
    logic [2:0] cnt;
    logic [2:0] disp;
    logic       tc;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_en = 1'b0;
  logic [2:0] cnt_a, disp_a, cnt_b, disp_b;
  logic       tc_a, tc_b;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  exp_t exp_q[$];
  logic [2:0] m_cnt = 3'd0;
  logic [2:0] m_disp = 3'd0;

  always #2 clk = ~clk;

  mod6_seq_counter #(.MODULUS(6), .WRAP_MODE(WRAP_AT_LAST)) dut_i (
    .clk(clk), .rst(rst), .cnt_en(cnt_en),
    .count_q(cnt_a), .disp_q(disp_a), .tc_pulse(tc_a));

  mod6_seq_counter #(.MODULUS(6), .WRAP_MODE(CLEAR_AT_OVER)) dut_c_i (
    .clk(clk), .rst(rst), .cnt_en(cnt_en),
    .count_q(cnt_b), .disp_q(disp_b), .tc_pulse(tc_b));

  task automatic check3(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // Driver: applies inputs just after an edge, queues the state expected now,
  // then advances the reference model for the coming edge.
  task automatic drive(input logic en, input logic r);
    exp_t it;
    @(posedge clk); #1;
    cnt_en = en;
    rst    = r;
    it.cnt  = m_cnt;
    it.disp = m_disp;
    it.tc   = (m_cnt == 3'd5) && en;
    exp_q.push_back(it);
    if (r) begin
      m_cnt  = 3'd0;
      m_disp = 3'd0;
    end else begin
      m_disp = m_cnt;
      if (en) m_cnt = (m_cnt == 3'd5) ? 3'd0 : m_cnt + 3'd1;
    end
  endtask

  // Monitor: compares both instances against the expected item at mid-cycle.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t it;
      it = exp_q.pop_front();
      check3("R2 R3 R5 R9 count (last-value)", cnt_a, it.cnt);
      check3("R7 display (last-value)", disp_a, it.disp);
      check1("R6 strobe (last-value)", tc_a, it.tc);
      check3("R8 count (clear-on-overflow)", cnt_b, it.cnt);
      check3("R8 R7 display (clear-on-overflow)", disp_b, it.disp);
      check1("R8 R6 strobe (clear-on-overflow)", tc_b, it.tc);
      checks++;
      if (cnt_a > 3'd5 || cnt_b > 3'd5 || disp_a > 3'd5 || disp_b > 3'd5) begin
        errors++;
        $display("FAIL R4 illegal value actual=%0d/%0d expected<=5", cnt_a, cnt_b);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check3("R1 reset count", cnt_a, 3'd0);
    check3("R1 reset display", disp_a, 3'd0);
    check1("R1 reset strobe", tc_a, 1'b0);
    check3("R1 reset count (clear mode)", cnt_b, 3'd0);

    // Long enabled run: two full wraps (R2, R3, R9, R6, R7, R8)
    for (int i = 0; i < 14; i++) drive(1'b1, 1'b0);
    // Alternating enable pattern (R5)
    for (int i = 0; i < 10; i++) drive(i[0], 1'b0);
    // Walk up to 5, then park there with enable low: no strobe, hold
    while (m_cnt != 3'd5) drive(1'b1, 1'b0);
    for (int i = 0; i < 4; i++) drive(1'b0, 1'b0);
    // Release at 5: strobe and wrap in the same cycle
    drive(1'b1, 1'b0);
    drive(1'b1, 1'b0);
    drive(1'b1, 1'b0);
    // Mid-sequence reset (R1)
    drive(1'b0, 1'b1);
    drive(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);
    drive(1'b0, 1'b0);
    @(posedge clk);
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule